// File: doc/BRIEF.md
# Auto-Negotiation Link Code Word Resolver

This block sits behind a fast-link-pulse burst decoder and turns its stream of decoded 16-bit link code words into a settled operating mode. It waits for three consecutive identical words from the link partner and keeps that word as the partner's ability word. It then waits for a second run of three identical words and picks the best mode that both ends advertise. The acknowledge bit is left out of every comparison, because a partner sets it partway through negotiation.

Alongside the code-word path, a parallel-detection path watches two line indications: raw 10BASE-T normal link pulses and 100BASE-TX idle. If either appears before negotiation has finished, the block fixes the speed to match the line and completes at half duplex. A restart input, driven by link loss or a management request, brings the block back to its power-on state. Pulse timing and burst decoding are handled upstream.

Top module: `an_word_resolver`

## Requirements
- R1: A run is three consecutive valid code words that compare equal with the acknowledge bit masked. Two equal words followed by a pause store nothing, and the third equal word completes the run.
- R2: The acknowledge bit is bit 14 of the code word. A word that differs only in bit 14 still extends a run, and the stored partner word always has bit 14 cleared.
- R3: A word that differs from the current reference in any other bit restarts the count at one and becomes the new reference. For example, A,A,B,B stores nothing and a further B completes a run of B.
- R4: At the end of the first run, the masked word appears on `partner_word` and `complete` stays low.
- R5: At the end of the second run, `partner_word` takes the second run's masked word. If a common mode exists, `complete` rises.
- R6: Ability bits are bit 5 = 10 half, bit 6 = 10 full, bit 7 = 100 half and bit 8 = 100 full. The chosen mode is the highest bit set in both `local_abl` and the partner word. The order is 100 full, then 100 half, then 10 full, then 10 half. `speed_100`=1 means 100 Mb/s and `full_dup`=1 means full duplex.
- R7: If the two ability sets share no mode, the second run leaves `complete` low and leaves `speed_100` and `full_dup` at 0.
- R8: While `complete` is low, a cycle with `nlp_seen` or `idle_seen` high sets `complete` at half duplex. Idle selects 100 Mb/s, NLP alone selects 10 Mb/s, and idle wins when both are high.
- R9: If parallel detection and the end of the second run fall in the same cycle, a code-word result with a common mode wins. Without a common mode, the parallel-detection result is used.
- R10: Once `complete` is high, further code words and line indications change none of the outputs.
- R11: Reset and `renegotiate` each synchronously clear `partner_word`, `speed_100`, `full_dup` and `complete` to 0 and discard any partial run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| renegotiate | input | 1 | Restart negotiation (link loss or request), synchronous |
| cw_valid | input | 1 | Code-word strobe from burst decoder |
| cw_data | input | 16 | Decoded link code word |
| local_abl | input | 4 | Local advertised abilities {100F,100H,10F,10H} |
| nlp_seen | input | 1 | 10BASE-T normal link pulses detected |
| idle_seen | input | 1 | 100BASE-TX idle detected |
| partner_word | output | 16 | Stored partner ability word, acknowledge bit cleared |
| speed_100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| full_dup | output | 1 | Resolved duplex, 1 = full |
| complete | output | 1 | Mode resolved |

## Verification
The code-word resolution at the end of the second run and a parallel-detection hit can land in the same clock cycle. The bench arranges this by raising `nlp_seen` for one cycle, one cycle after the last word of the second run is strobed. That is the cycle in which the run detector's registered hit reaches the mode logic. When the abilities share a mode, the expected result is the negotiated one. When they share none, the expected result is the 10 Mb/s half-duplex mode that parallel detection picks. A full sweep of all 256 local and partner ability pairs checks the priority order against an arithmetic model.

// File: rtl/an_res_pkg.sv
// Package: shared types for the link code word resolver.
// Assumes: the ability field holds four bits ordered 10H,10F,100H,100F from the LSB up.
package an_res_pkg;
    localparam int N_ABL = 4;

    typedef enum logic [1:0] {
        PH_FIRST  = 2'd0,   // waiting for the first run
        PH_SECOND = 2'd1,   // partner word stored, waiting for the confirming run
        PH_HALT   = 2'd2    // second run seen, no further runs accepted
    } phase_t;
endpackage

// File: rtl/an_run_tracker.sv
// Module: an_run_tracker
// Counts consecutive identical code words with the acknowledge bit masked.
// It emits a one-cycle registered hit carrying the masked word when RUN_LEN
// words match, then starts counting afresh.
// Assumes: RUN_LEN >= 2 and ACK_BIT < CW_W.
module an_run_tracker #(
    parameter int CW_W    = 16,
    parameter int ACK_BIT = 14,
    parameter int RUN_LEN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cw_valid,
    input  logic [CW_W-1:0] cw_data,
    output logic            run_hit,
    output logic [CW_W-1:0] run_word
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CW_W-1:0] ACK_MASK = ~(CW_W'(1) << ACK_BIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CW_W-1:0]  ref_q;
    logic [CW_W-1:0]  masked;
    logic             same;

    // Mask the acknowledge bit and compare with the reference word.
    always_comb begin
        masked = cw_data & ACK_MASK;
        same   = (cnt_q != '0) && (masked == ref_q);
    end

    // Advance, restart or complete the run on each strobed word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q    <= '0;
            ref_q    <= '0;
            run_hit  <= 1'b0;
            run_word <= '0;
        end else begin
            run_hit <= 1'b0;
            if (cw_valid) begin
                if (same) begin
                    if (cnt_q == CNT_W'(RUN_LEN - 1)) begin
                        cnt_q    <= '0;
                        run_hit  <= 1'b1;
                        run_word <= ref_q;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end else begin
                    ref_q <= masked;
                    cnt_q <= CNT_W'(1);
                end
            end
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(RUN_LEN));

    // R1
    hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_hit |-> $past(cw_valid));

    // R2
    run_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_hit |-> !run_word[ACK_BIT]);
endmodule

// File: rtl/an_mode_pick.sv
// Module: an_mode_pick
// Picks the highest ability present in both sets. A higher index means a
// higher priority. The upper half of the indices is 100 Mb/s and odd
// indices are full duplex.
// Assumes: N_ABL is even and the field order is 10H,10F,100H,100F.
module an_mode_pick #(
    parameter int N_ABL = 4
) (
    input  logic [N_ABL-1:0] local_abl,
    input  logic [N_ABL-1:0] partner_abl,
    output logic             found,
    output logic             speed_100,
    output logic             full_dup
);
    localparam int SEL_W = (N_ABL > 1) ? $clog2(N_ABL) : 1;

    logic [N_ABL-1:0] common;
    logic [SEL_W-1:0] sel;

    // Scan the common set from low to high so that the highest bit wins.
    always_comb begin
        common = local_abl & partner_abl;
        sel    = '0;
        for (int i = 0; i < N_ABL; i++) begin
            if (common[i]) sel = SEL_W'(i);
        end
        found     = |common;
        speed_100 = found && (sel >= SEL_W'(N_ABL / 2));
        full_dup  = found && sel[0];
    end
endmodule

// File: rtl/an_pd_select.sv
// Module: an_pd_select
// Parallel-detection speed choice from the two raw line indications.
// Idle takes precedence over normal link pulses.
// Assumes: both indications are already synchronous to clk.
module an_pd_select (
    input  logic nlp_seen,
    input  logic idle_seen,
    output logic pd_hit,
    output logic pd_speed_100
);
    // Flag a detection and choose the speed from the line type.
    always_comb begin
        pd_hit       = nlp_seen | idle_seen;
        pd_speed_100 = idle_seen;
    end
endmodule

// File: rtl/an_word_resolver.sv
// Module: an_word_resolver (top)
// Accepts the partner's ability word after two runs of matching code words
// and resolves the best common mode. A parallel-detection fallback fixes
// the speed at half duplex. Restart clears everything.
// Assumes: the ability field sits at ABL_LSB in the code word and the
// acknowledge bit is ACK_BIT.
module an_word_resolver
    import an_res_pkg::*;
#(
    parameter int CW_W    = 16,
    parameter int ACK_BIT = 14,
    parameter int RUN_LEN = 3,
    parameter int ABL_LSB = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             renegotiate,
    input  logic             cw_valid,
    input  logic [CW_W-1:0]  cw_data,
    input  logic [N_ABL-1:0] local_abl,
    input  logic             nlp_seen,
    input  logic             idle_seen,
    output logic [CW_W-1:0]  partner_word,
    output logic             speed_100,
    output logic             full_dup,
    output logic             complete
);
    logic            run_hit;
    logic [CW_W-1:0] run_word;
    logic            pick_found, pick_speed, pick_full;
    logic            pd_hit, pd_speed;
    logic            neg_fire;
    phase_t          phase_q;

    an_run_tracker #(.CW_W(CW_W), .ACK_BIT(ACK_BIT), .RUN_LEN(RUN_LEN)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (renegotiate),
        .cw_valid (cw_valid),
        .cw_data  (cw_data),
        .run_hit  (run_hit),
        .run_word (run_word)
    );

    an_mode_pick #(.N_ABL(N_ABL)) u_pick (
        .local_abl   (local_abl),
        .partner_abl (run_word[ABL_LSB +: N_ABL]),
        .found       (pick_found),
        .speed_100   (pick_speed),
        .full_dup    (pick_full)
    );

    an_pd_select u_pd (
        .nlp_seen     (nlp_seen),
        .idle_seen    (idle_seen),
        .pd_hit       (pd_hit),
        .pd_speed_100 (pd_speed)
    );

    // A code-word resolution that takes effect this cycle.
    always_comb begin
        neg_fire = run_hit && (phase_q == PH_SECOND) && pick_found && !complete;
    end

    // Negotiation phase, stored partner word and resolved mode.
    always_ff @(posedge clk) begin
        if (!rst_n || renegotiate) begin
            phase_q      <= PH_FIRST;
            partner_word <= '0;
            speed_100    <= 1'b0;
            full_dup     <= 1'b0;
            complete     <= 1'b0;
        end else if (!complete) begin
            if (run_hit && phase_q == PH_FIRST) begin
                partner_word <= run_word;
                phase_q      <= PH_SECOND;
            end else if (run_hit && phase_q == PH_SECOND) begin
                partner_word <= run_word;
                phase_q      <= PH_HALT;
            end
            if (neg_fire) begin
                complete  <= 1'b1;
                speed_100 <= pick_speed;
                full_dup  <= pick_full;
            end else if (pd_hit) begin
                complete  <= 1'b1;
                speed_100 <= pd_speed;
                full_dup  <= 1'b0;
            end
        end
    end

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !renegotiate) |=> (complete && $stable(partner_word)
                                        && $stable(speed_100) && $stable(full_dup)));

    // R11
    restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        renegotiate |=> (!complete && partner_word == '0));

    // R8
    pd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_hit && !complete && !neg_fire && !renegotiate) |=> (complete && !full_dup));

    // R7
    nofit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_hit && phase_q == PH_SECOND && !pick_found && !pd_hit && !complete
         && !renegotiate) |=> !complete);

    // R4
    first_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_hit && phase_q == PH_FIRST && !pd_hit && !complete && !renegotiate)
        |=> (!complete && partner_word[ACK_BIT] == 1'b0));
endmodule

// File: tb/test_an_word_resolver.sv
// Bench for an_word_resolver: sweeps every pair of ability sets and checks
// the run counting, the parallel detection, the same-cycle collision and
// restart against an arithmetic model.
module test_an_word_resolver;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ACK = 16'h4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        renegotiate = 1'b0;
    logic        cw_valid = 1'b0;
    logic [15:0] cw_data = '0;
    logic [3:0]  local_abl = '0;
    logic        nlp_seen = 1'b0;
    logic        idle_seen = 1'b0;
    logic [15:0] partner_word;
    logic        speed_100, full_dup, complete;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    an_word_resolver i_an_word_resolver (
        .clk(clk), .rst_n(rst_n), .renegotiate(renegotiate),
        .cw_valid(cw_valid), .cw_data(cw_data), .local_abl(local_abl),
        .nlp_seen(nlp_seen), .idle_seen(idle_seen),
        .partner_word(partner_word), .speed_100(speed_100),
        .full_dup(full_dup), .complete(complete)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pause(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cw_valid  = 1'b0;
            nlp_seen  = 1'b0;
            idle_seen = 1'b0;
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cw_valid = 1'b1;
        cw_data  = w;
    endtask

    task automatic restart();
        @(negedge clk);
        cw_valid    = 1'b0;
        renegotiate = 1'b1;
        @(negedge clk);
        renegotiate = 1'b0;
    endtask

    task automatic check_out(input string req, input logic [15:0] pw,
                             input logic sp, input logic fd, input logic dn);
        check(req, {16'h0, partner_word}, {16'h0, pw});
        check(req, {29'h0, speed_100, full_dup, complete}, {29'h0, sp, fd, dn});
    endtask

    // Expected {found, speed, full} for two ability nibbles.
    function automatic logic [2:0] model(input logic [3:0] l, input logic [3:0] p);
        logic [3:0] c;
        c = l & p;
        if (c[3])      return 3'b111;
        else if (c[2]) return 3'b110;
        else if (c[1]) return 3'b101;
        else if (c[0]) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [15:0] word_of(input logic [3:0] a);
        return {7'h0, a, 5'h01};
    endfunction

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [2:0]  e;
        logic [15:0] wa, wb;
        pause(3);
        // R11 reset state
        check_out("R11 reset", 16'h0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        pause(2);
        check_out("R11 after reset", 16'h0, 0, 0, 0);

        // R6 / R4 / R5 / R7 full sweep of ability pairs
        for (int l = 0; l < 16; l++) begin
            for (int p = 0; p < 16; p++) begin
                restart();
                local_abl = 4'(l);
                wa = word_of(4'(p));
                for (int k = 0; k < 3; k++) send(wa);
                pause(3);
                check_out("R4 first run", wa, 0, 0, 0);
                for (int k = 0; k < 3; k++) send(wa | ACK);
                pause(3);
                e = model(4'(l), 4'(p));
                // R6 R5 R7
                check_out(e[2] ? "R6 R5 resolve" : "R7 no common", wa, e[1], e[0], e[2]);
            end
        end

        // R1 two words are not a run, the third is
        restart();
        local_abl = 4'hF;
        wa = word_of(4'b1000);
        send(wa); send(wa);
        pause(3);
        check_out("R1 two words", 16'h0, 0, 0, 0);
        send(wa);
        pause(3);
        check_out("R1 third word", wa, 0, 0, 0);

        // R2 acknowledge bit ignored in comparison and cleared in storage
        restart();
        send(wa); send(wa | ACK); send(wa);
        pause(3);
        check_out("R2 ack masked", wa, 0, 0, 0);
        restart();
        send(wa | ACK); send(wa | ACK); send(wa | ACK);
        pause(3);
        check_out("R2 ack cleared", wa, 0, 0, 0);

        // R3 mismatch restarts the count with the new reference
        restart();
        wb = word_of(4'b0100);
        send(wa); send(wa); send(wb); send(wb);
        pause(3);
        check_out("R3 after A,A,B,B", 16'h0, 0, 0, 0);
        send(wb);
        pause(3);
        check_out("R3 run of B", wb, 0, 0, 0);

        // R8 parallel detection
        restart();
        @(negedge clk); nlp_seen = 1'b1;
        pause(2);
        check_out("R8 nlp", 16'h0, 0, 0, 1);
        restart();
        @(negedge clk); idle_seen = 1'b1;
        pause(2);
        check_out("R8 idle", 16'h0, 1, 0, 1);
        restart();
        @(negedge clk); idle_seen = 1'b1; nlp_seen = 1'b1;
        pause(2);
        check_out("R8 both", 16'h0, 1, 0, 1);
        restart();
        send(wa); send(wa); send(wa);
        @(negedge clk); cw_valid = 1'b0; idle_seen = 1'b1;
        pause(2);
        check_out("R8 during wait", wa, 1, 0, 1);

        // R9 collision, common mode present: code word wins
        restart();
        local_abl = 4'hF;
        for (int k = 0; k < 3; k++) send(wa);
        pause(2);
        for (int k = 0; k < 3; k++) send(wa | ACK);
        @(negedge clk); cw_valid = 1'b0; nlp_seen = 1'b1;
        pause(2);
        check_out("R9 code word wins", wa, 1, 1, 1);

        // R9 collision, no common mode: parallel detection used
        restart();
        local_abl = 4'b0001;
        for (int k = 0; k < 3; k++) send(wa);
        pause(2);
        for (int k = 0; k < 3; k++) send(wa | ACK);
        @(negedge clk); cw_valid = 1'b0; nlp_seen = 1'b1;
        pause(2);
        check_out("R9 pd used", wa, 0, 0, 1);

        // R10 nothing changes after completion
        restart();
        local_abl = 4'hF;
        for (int k = 0; k < 6; k++) send(wa);
        pause(3);
        check_out("R10 done", wa, 1, 1, 1);
        wb = word_of(4'b0001);
        for (int k = 0; k < 6; k++) send(wb);
        @(negedge clk); cw_valid = 1'b0; nlp_seen = 1'b1;
        @(negedge clk); nlp_seen = 1'b0; idle_seen = 1'b1;
        pause(3);
        check_out("R10 held", wa, 1, 1, 1);

        // R11 restart clears a completed result
        restart();
        pause(1);
        check_out("R11 restart", 16'h0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule